// File: doc/BRIEF.md
# Two-Level Power Throttle Controller

This block watches a stream of board power samples and decides when the clock must be slowed. It has two stacked levels. The mild level asks for a one-step frequency drop of about 100 MHz. The severe level forces the lowest operating frequency, around 600 MHz. Each level has its own trip point, which is a fixed percentage of the card's rated design power. Each level also has its own dwell time: power must stay above the trip point for that many consecutive sample ticks before the level engages. Each level has its own release margin below the trip point, so the controller does not flap between throttled and normal operation.

The mild level releases 15 W below its trip point on cards rated 250 W or less. Above that rating it releases 20 W below. The severe level always releases 40 W below its trip point. Once the severe level engages, a timer starts. When it expires, the block raises a request to lower the core voltage. The request and its timer are dropped at once if the severe level releases first.

Power samples are unsigned fixed-point watts with `FRAC_BITS` fractional bits, so the default unit is a quarter watt. The rated power is an integer count of watts. The trip points are captured from it on reset and on each configuration-load strobe.

Top module: `pwr_throttle_ctrl`

## Requirements
- R1: Out of reset, `mild_req`, `severe_req` and `vred_req` are 0 and `freq_sel` is 0.
- R2: The mild trip point is floor(rated_pwr·105·2^FRAC_BITS/100) and the severe trip point is floor(rated_pwr·125·2^FRAC_BITS/100), both in sample units. They are captured only on reset or on a cycle with `cfg_load` high. A change of `rated_pwr` alone has no effect.
- R3: `mild_req` rises at the clock edge of the MILD_DWELL_TICKS-th consecutive tick whose sample is strictly above the mild trip point. `mild_req` changes only on cycles with `tick` high.
- R4: A tick whose sample is at or below a level's trip point clears that level's dwell count. Cycles with `tick` low are ignored and neither advance nor clear the count.
- R5: An active `mild_req` falls on a tick whose sample is at or below the mild trip point minus 15 W (rated_pwr ≤ 250) or minus 20 W (rated_pwr > 250). Above that point it holds.
- R6: `severe_req` rises after SEVERE_DWELL_TICKS consecutive ticks above the severe trip point, under the same counting rule. It falls on a tick whose sample is at or below the severe trip point minus 40 W.
- R7: `freq_sel` is 2 (minimum) whenever `severe_req` is high, whatever the mild state. Otherwise it is 1 (one step down) when `mild_req` is high, and 0 (nominal) when neither is high.
- R8: `vred_req` rises at the edge of the VRED_DELAY_TICKS-th tick after the edge where `severe_req` rose, with severe still high.
- R9: `vred_req` drops together with `severe_req`. A severe release before the delay expires clears the pending count, so the next severe episode waits the full delay again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Sample strobe; `pwr_sample` is evaluated only when high |
| pwr_sample | input | PWR_W (13) | Measured power, fixed-point watts |
| rated_pwr | input | RATED_W (10) | Rated design power, whole watts |
| cfg_load | input | 1 | Recompute trip points from `rated_pwr` |
| mild_req | output | 1 | One-step frequency reduction request |
| severe_req | output | 1 | Minimum-frequency request |
| vred_req | output | 1 | Delayed core-voltage reduction request |
| freq_sel | output | 2 | 0 nominal, 1 step down, 2 minimum |

## Verification
The hardest case to reach is a voltage request cancelled part-way through its delay. The timer then has to restart from zero rather than resume. To get there, the bench holds power above the severe point until severe engages. It lets part of the delay elapse, dips one sample just below the severe release point, and climbs again. The new request must wait the full delay, so a count left over from the first episode would show up as an early rise. The bench also probes each trip point one quantum below it, exactly at it, and one quantum above it. It uses a rated power whose percentages do not divide evenly, and a rating exactly at the 250 W boundary for the margin choice.

// File: rtl/pwr_throttle_pkg.sv
// Package: shared constants and the frequency-select encoding for the
// two-level power throttle controller.
package pwr_throttle_pkg;

    typedef enum logic [1:0] {
        FREQ_NOMINAL   = 2'd0,
        FREQ_STEP_DOWN = 2'd1,
        FREQ_MINIMUM   = 2'd2
    } freq_sel_e;

    // Trip points as percentages of rated design power.
    localparam int unsigned MILD_PCT         = 105;
    localparam int unsigned SEVERE_PCT       = 125;

    // Release margins in whole watts.
    localparam int unsigned MILD_MARGIN_LO_W = 15;
    localparam int unsigned MILD_MARGIN_HI_W = 20;
    localparam int unsigned SEVERE_MARGIN_W  = 40;

    // Ratings above this (whole watts) use the larger mild margin.
    localparam int unsigned MARGIN_SPLIT_W   = 250;

endpackage

// File: rtl/pwr_thr_calc.sv
// Module: pwr_thr_calc
// Computes the trip and release points of both throttle levels from the
// rated design power and holds them in registers.
// Assumes: rated_pwr is whole watts, and the outputs are fixed-point watts
// with FRAC bits of fraction. Percentages are rounded down. Release points
// saturate at zero. Values are captured on reset and on cfg_load only.
module pwr_thr_calc
    import pwr_throttle_pkg::*;
#(
    parameter int unsigned RATED_W = 10,
    parameter int unsigned FRAC    = 2,
    parameter int unsigned PWR_W   = RATED_W + 1 + FRAC
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_load,
    input  logic [RATED_W-1:0] rated_pwr,
    output logic [PWR_W-1:0]   th_mild,
    output logic [PWR_W-1:0]   rel_mild,
    output logic [PWR_W-1:0]   th_sev,
    output logic [PWR_W-1:0]   rel_sev
);

    localparam int unsigned PROD_W = RATED_W + FRAC + 8;
    localparam logic [PWR_W-1:0] M_LO  = PWR_W'(MILD_MARGIN_LO_W * (1 << FRAC));
    localparam logic [PWR_W-1:0] M_HI  = PWR_W'(MILD_MARGIN_HI_W * (1 << FRAC));
    localparam logic [PWR_W-1:0] M_SEV = PWR_W'(SEVERE_MARGIN_W * (1 << FRAC));

    // Percentage of the rating in fixed point, rounded down.
    function automatic logic [PWR_W-1:0] pct_of(input logic [RATED_W-1:0] r,
                                                input int unsigned pct);
        logic [PROD_W-1:0] prod;
        prod = (PROD_W'(r) * PROD_W'(pct)) << FRAC;
        return PWR_W'(prod / PROD_W'(100));
    endfunction

    // Subtraction that stops at zero.
    function automatic logic [PWR_W-1:0] sat_sub(input logic [PWR_W-1:0] a,
                                                 input logic [PWR_W-1:0] b);
        return (a > b) ? (a - b) : '0;
    endfunction

    logic [PWR_W-1:0] th_mild_d, th_sev_d, mild_margin_d;

    // Combinational trip points and rating-dependent mild margin.
    always_comb begin
        th_mild_d     = pct_of(rated_pwr, MILD_PCT);
        th_sev_d      = pct_of(rated_pwr, SEVERE_PCT);
        mild_margin_d = (32'(rated_pwr) > 32'(MARGIN_SPLIT_W)) ? M_HI : M_LO;
    end

    // Capture all four points on reset or on a configuration load.
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_load) begin
            th_mild  <= th_mild_d;
            rel_mild <= sat_sub(th_mild_d, mild_margin_d);
            th_sev   <= th_sev_d;
            rel_sev  <= sat_sub(th_sev_d, M_SEV);
        end
    end

endmodule

// File: rtl/pwr_level.sv
// Module: pwr_level
// One throttle level: a dwell counter of consecutive over-threshold ticks
// and a hysteretic active flag.
// Assumes: rel < th. Samples are evaluated only on tick, and non-tick
// cycles leave the state untouched. DWELL >= 1.
module pwr_level #(
    parameter int unsigned PWR_W = 13,
    parameter int unsigned DWELL = 300
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [PWR_W-1:0] sample,
    input  logic [PWR_W-1:0] th,
    input  logic [PWR_W-1:0] rel,
    output logic             active
);

    localparam int unsigned CW = (DWELL > 1) ? $clog2(DWELL) : 1;
    localparam logic [CW-1:0] LAST = CW'(DWELL - 1);

    logic [CW-1:0] cnt;

    // Dwell counting while idle, hysteretic release while active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            active <= 1'b0;
        end else if (tick) begin
            if (active) begin
                cnt <= '0;
                if (sample <= rel) begin
                    active <= 1'b0;
                end
            end else if (sample > th) begin
                if (cnt == LAST) begin
                    cnt    <= '0;
                    active <= 1'b1;
                end else begin
                    cnt <= cnt + CW'(1);
                end
            end else begin
                cnt <= '0;
            end
        end
    end

endmodule

// File: rtl/pwr_vred_timer.sv
// Module: pwr_vred_timer
// Counts ticks while the severe level is held and raises the voltage
// reduction request when DELAY ticks have passed.
// Assumes: severe is a registered level. The request is gated by severe so
// that it drops in the same cycle; the count clears while severe is low.
module pwr_vred_timer #(
    parameter int unsigned DELAY = 350
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic severe,
    output logic vred
);

    localparam int unsigned CW = (DELAY > 1) ? $clog2(DELAY) : 1;
    localparam logic [CW-1:0] LAST = CW'(DELAY - 1);

    logic [CW-1:0] cnt;
    logic          fired;

    // Delay count after severe entry; clear everything once severe ends.
    always_ff @(posedge clk) begin
        if (!rst_n || !severe) begin
            cnt   <= '0;
            fired <= 1'b0;
        end else if (tick && !fired) begin
            if (cnt == LAST) begin
                fired <= 1'b1;
            end else begin
                cnt <= cnt + CW'(1);
            end
        end
    end

    // Request visible only while severe throttling is still held.
    assign vred = fired & severe;

endmodule

// File: rtl/pwr_throttle_ctrl.sv
// Module: pwr_throttle_ctrl (top)
// Two stacked power throttle levels with hysteresis, a frequency select
// with severe priority, and a delayed voltage reduction request.
// Assumes: the tick period sets the units of the three tick-count
// parameters. pwr_sample is fixed-point watts with FRAC_BITS fraction.
module pwr_throttle_ctrl
    import pwr_throttle_pkg::*;
#(
    parameter int unsigned RATED_W            = 10,
    parameter int unsigned FRAC_BITS          = 2,
    parameter int unsigned MILD_DWELL_TICKS   = 300,
    parameter int unsigned SEVERE_DWELL_TICKS = 50,
    parameter int unsigned VRED_DELAY_TICKS   = 350,
    localparam int unsigned PWR_W             = RATED_W + 1 + FRAC_BITS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic [PWR_W-1:0]   pwr_sample,
    input  logic [RATED_W-1:0] rated_pwr,
    input  logic               cfg_load,
    output logic               mild_req,
    output logic               severe_req,
    output logic               vred_req,
    output logic [1:0]         freq_sel
);

    logic [PWR_W-1:0] th_mild_q, rel_mild_q, th_sev_q, rel_sev_q;
    freq_sel_e        freq_d;

    pwr_thr_calc #(
        .RATED_W (RATED_W),
        .FRAC    (FRAC_BITS),
        .PWR_W   (PWR_W)
    ) u_calc (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_load  (cfg_load),
        .rated_pwr (rated_pwr),
        .th_mild   (th_mild_q),
        .rel_mild  (rel_mild_q),
        .th_sev    (th_sev_q),
        .rel_sev   (rel_sev_q)
    );

    pwr_level #(
        .PWR_W (PWR_W),
        .DWELL (MILD_DWELL_TICKS)
    ) u_mild (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .sample (pwr_sample),
        .th     (th_mild_q),
        .rel    (rel_mild_q),
        .active (mild_req)
    );

    pwr_level #(
        .PWR_W (PWR_W),
        .DWELL (SEVERE_DWELL_TICKS)
    ) u_severe (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .sample (pwr_sample),
        .th     (th_sev_q),
        .rel    (rel_sev_q),
        .active (severe_req)
    );

    pwr_vred_timer #(
        .DELAY (VRED_DELAY_TICKS)
    ) u_vred (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .severe (severe_req),
        .vred   (vred_req)
    );

    // Frequency select: severe overrides mild.
    always_comb begin
        if (severe_req)    freq_d = FREQ_MINIMUM;
        else if (mild_req) freq_d = FREQ_STEP_DOWN;
        else               freq_d = FREQ_NOMINAL;
    end

    assign freq_sel = freq_d;

endmodule

// File: rtl/pwr_throttle_chk.sv
// Module: pwr_throttle_chk
// Property checker for pwr_throttle_ctrl, attached by bind below.
module pwr_throttle_chk #(
    parameter int unsigned PWR_W            = 13,
    parameter int unsigned VRED_DELAY_TICKS = 350
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic [PWR_W-1:0] pwr_sample,
    input logic [PWR_W-1:0] th_mild,
    input logic [PWR_W-1:0] rel_mild,
    input logic [PWR_W-1:0] th_sev,
    input logic [PWR_W-1:0] rel_sev,
    input logic             mild_req,
    input logic             severe_req,
    input logic             vred_req,
    input logic [1:0]       freq_sel
);

    localparam int unsigned CW = $clog2(VRED_DELAY_TICKS + 1);
    logic [CW-1:0] sev_ticks;

    // Independent count of ticks seen with severe held since its entry.
    always_ff @(posedge clk) begin
        if (!rst_n || !severe_req) sev_ticks <= '0;
        else if (tick && sev_ticks != CW'(VRED_DELAY_TICKS)) sev_ticks <= sev_ticks + CW'(1);
    end

    // R2
    thr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (th_sev >= th_mild) && (rel_mild <= th_mild) && (rel_sev <= th_sev));

    // R3
    mild_tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(mild_req) && $stable(severe_req));

    // R3
    mild_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mild_req) |-> $past(pwr_sample > th_mild));

    // R5
    mild_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mild_req) |-> $past(pwr_sample <= rel_mild));

    // R6
    sev_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(severe_req) |-> $past(pwr_sample > th_sev));

    // R6
    sev_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(severe_req) |-> $past(pwr_sample <= rel_sev));

    // R7
    freq_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        severe_req |-> freq_sel == 2'd2);

    // R8
    vred_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vred_req) |-> sev_ticks == CW'(VRED_DELAY_TICKS));

    // R9
    vred_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(severe_req) |-> !vred_req);

endmodule

bind pwr_throttle_ctrl pwr_throttle_chk #(
    .PWR_W            (PWR_W),
    .VRED_DELAY_TICKS (VRED_DELAY_TICKS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .pwr_sample (pwr_sample),
    .th_mild    (th_mild_q),
    .rel_mild   (rel_mild_q),
    .th_sev     (th_sev_q),
    .rel_sev    (rel_sev_q),
    .mild_req   (mild_req),
    .severe_req (severe_req),
    .vred_req   (vred_req),
    .freq_sel   (freq_sel)
);

// File: tb/sim_pwr_throttle_ctrl.sv
// Directed bench for pwr_throttle_ctrl. Samples are in quarter watts.
module sim_pwr_throttle_ctrl;

    localparam int MILD_D = 12;
    localparam int SEV_D  = 5;
    localparam int VRED_D = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [12:0] pwr_sample = '0;
    logic [9:0]  rated_pwr = 10'd200;
    logic        cfg_load = 1'b0;
    logic        mild_req, severe_req, vred_req;
    logic [1:0]  freq_sel;

    int n_chk = 0;
    int n_bad = 0;

    pwr_throttle_ctrl #(
        .RATED_W            (10),
        .FRAC_BITS          (2),
        .MILD_DWELL_TICKS   (MILD_D),
        .SEVERE_DWELL_TICKS (SEV_D),
        .VRED_DELAY_TICKS   (VRED_D)
    ) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .pwr_sample (pwr_sample),
        .rated_pwr  (rated_pwr),
        .cfg_load   (cfg_load),
        .mild_req   (mild_req),
        .severe_req (severe_req),
        .vred_req   (vred_req),
        .freq_sel   (freq_sel)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, look just after the rising edge.
    task automatic step(input int s, input bit tk = 1'b1);
        @(negedge clk);
        pwr_sample = 13'(s);
        tick       = tk;
        @(posedge clk);
        #1;
    endtask

    task automatic steps(input int s, input int n);
        for (int i = 0; i < n; i++) step(s);
    endtask

    task automatic load(input int r);
        @(negedge clk);
        rated_pwr = 10'(r);
        cfg_load  = 1'b1;
        tick      = 1'b0;
        @(posedge clk);
        #1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 mild", mild_req, 0);
        check("R1 severe", severe_req, 0);
        check("R1 vred", vred_req, 0);
        check("R1 freq", freq_sel, 0);
    endtask

    // Rating 200 W: mild trip 840, release 780; severe trip 1000, release 840.
    task automatic t_mild_basic;
        load(200);
        steps(841, MILD_D - 1);
        check("R3 before dwell", mild_req, 0);
        step(841);
        check("R3 after dwell", mild_req, 1);
        check("R7 step down", freq_sel, 1);
        steps(800, 3);
        check("R5 hold", mild_req, 1);
        step(781);
        check("R5 hold one above", mild_req, 1);
        step(780);
        check("R5 release 15W", mild_req, 0);
        check("R7 nominal", freq_sel, 0);
    endtask

    task automatic t_dwell_reset;
        steps(841, MILD_D - 1);
        step(840);
        check("R4 equal clears", mild_req, 0);
        steps(841, MILD_D - 1);
        check("R4 recount", mild_req, 0);
        step(841);
        check("R4 full recount", mild_req, 1);
        step(0);
        steps(841, 6);
        for (int i = 0; i < 3; i++) step(0, 1'b0);
        check("R4 idle no change", mild_req, 0);
        steps(841, MILD_D - 7);
        check("R4 idle ignored pre", mild_req, 0);
        step(841);
        check("R4 idle ignored", mild_req, 1);
        step(0);
    endtask

    // 300 W: trip 1260, release 1180. 250 W: trip 1050, release 990.
    task automatic t_margins;
        load(300);
        steps(1261, MILD_D);
        check("R5 300W assert", mild_req, 1);
        step(1181);
        check("R5 300W hold", mild_req, 1);
        step(1180);
        check("R5 300W release 20W", mild_req, 0);
        load(250);
        steps(1051, MILD_D);
        check("R5 250W assert", mild_req, 1);
        step(991);
        check("R5 250W hold", mild_req, 1);
        step(990);
        check("R5 250W release 15W", mild_req, 0);
    endtask

    // 203 W: mild trip floor(852.6) = 852.
    task automatic t_floor;
        load(203);
        steps(852, MILD_D);
        check("R2 floor at trip", mild_req, 0);
        steps(853, MILD_D);
        check("R2 floor above trip", mild_req, 1);
        step(0);
        @(negedge clk);
        rated_pwr = 10'd400;
        steps(853, MILD_D);
        check("R2 no load ignored", mild_req, 1);
        step(0);
        check("R2 release", mild_req, 0);
    endtask

    task automatic t_severe;
        load(200);
        steps(1001, SEV_D - 1);
        check("R6 before dwell", severe_req, 0);
        step(1001);
        check("R6 assert", severe_req, 1);
        check("R7 minimum", freq_sel, 2);
        steps(1001, MILD_D - SEV_D);
        check("R7 mild also on", mild_req, 1);
        check("R7 priority", freq_sel, 2);
        check("R8 before delay", vred_req, 0);
        step(1001);
        check("R8 after delay", vred_req, 1);
        steps(841, 2);
        check("R6 hold", severe_req, 1);
        step(840);
        check("R6 release 40W", severe_req, 0);
        check("R9 drop with severe", vred_req, 0);
        check("R7 back to step", freq_sel, 1);
        step(0);
    endtask

    task automatic t_cancel;
        steps(1001, SEV_D + 4);
        check("R9 partial", vred_req, 0);
        step(800);
        check("R9 early release", severe_req, 0);
        steps(1001, SEV_D);
        check("R9 re-entry", severe_req, 1);
        steps(1001, VRED_D - 1);
        check("R9 full delay pre", vred_req, 0);
        step(1001);
        check("R9 full delay", vred_req, 1);
        step(0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        step(0);
        t_reset();
        t_mild_basic();
        t_dwell_reset();
        t_margins();
        t_floor();
        t_severe();
        t_cancel();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule